// File: doc/BRIEF.md
# Multi-Channel Doorbell Mailbox

This block links a host processor to an embedded controller through twelve logical channels. A shared data window holds 92 words of 32 bits. Its lower part, byte offsets 0x000 to 0x0df, holds the outgoing payloads. Each channel owns a fixed slice of it, and the slices have unequal sizes. The upper part, 0x0e0 to 0x16f, holds the incoming replies, sliced the same way. A control window carries one bit per channel in each of its registers.

The host writes payload words and then rings a channel's doorbell. That sets the channel's transmit-busy bit. The bit stays set until the remote side strobes its consume line. The remote side fills its reply slice through a word-addressed port of its own and strobes respond, which sets the channel's receive flag. Any receive flag drives the single interrupt line, so the host has to poll transmit-busy to learn that a send has finished. The host acknowledges a reply by writing the acknowledge register. The host port works only while the mailbox clock enable is high. The remote port is not gated.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset, every transmit-busy and receive flag is 0, `irq` is 0, and both status registers read 0.
- R2: A host write with `hst_ctl`=0 to a byte address in 0x000..0x0df stores the 32-bit word at index address/4. A later host read of that address returns the word.
- R3: Writing the doorbell register (control offset 0x004) sets transmit-busy for every channel n whose bit n is 1. Bits written as 0 change nothing. Transmit status reads at offset 0x000 and also appears on `tx_busy`.
- R4: A consume strobe on bit n clears transmit-busy of channel n. When a doorbell and a consume hit the same channel in one cycle, the bit ends up set.
- R5: A respond strobe on bit n sets receive flag n, which reads at offset 0x078. Writing bit n to the acknowledge register (offset 0x074) clears it, and bits written as 0 change nothing. When a respond and an acknowledge hit the same channel in one cycle, the bit ends up set.
- R6: `irq` is the OR of all receive flags, delayed by one clock. Transmit-busy activity never raises it.
- R7: Host writes to the reply area (0x0e0..0x16f) are ignored. Remote writes to word indices 0..55 (the outgoing area) are ignored.
- R8: Remote writes to word indices 56..91 are stored. The host reads them at byte address 4×index, and `rmt_rdata` returns the addressed word in the same cycle.
- R9: While `mbx_clk_en` is 0, host writes, doorbells and acknowledges have no effect and `hst_rdata` holds its value.
- R10: Control reads of 0x004, 0x074 and any unmapped offset return 0, and data reads at byte address 0x170 or above return 0.
- R11: `hst_rdata` shows the read result one clock after the read request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbx_clk_en | input | 1 | Mailbox clock enable; the host port is dead while low |
| hst_req | input | 1 | Host access request |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_ctl | input | 1 | 1 selects the control window, 0 the data window |
| hst_addr | input | ADDR_W | Host byte address |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data, registered |
| rmt_consume | input | 12 | Per-channel strobe that clears transmit-busy |
| rmt_respond | input | 12 | Per-channel strobe that sets the receive flag |
| rmt_we | input | 1 | Remote data write |
| rmt_idx | input | ADDR_W-2 | Remote word index |
| rmt_wdata | input | DATA_W | Remote write data |
| rmt_rdata | output | DATA_W | Remote read data, combinational |
| tx_busy | output | 12 | Transmit-busy bits |
| irq | output | 1 | Shared receive interrupt |

## Verification
The bench builds the block with its defaults: a 9-bit byte address, 32-bit words and the fixed twelve-channel slice table. These bring the area boundary words within reach: indices 55 and 56, and index 91 (channel 11's reply). They also reach the first address past the window, 0x170, and the highest, 0x1fc. Channels 0, 7 and 11 show that bit n maps to channel n at both ends of the register. Same-cycle collisions are driven on both the transmit and the receive flags.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int NUM_CH = 12;

  localparam int OFF_TX_STAT  = 'h000;
  localparam int OFF_DOORBELL = 'h004;
  localparam int OFF_ACK      = 'h074;
  localparam int OFF_RX_STAT  = 'h078;

  typedef enum logic [2:0] {
    SEL_TXS,
    SEL_DOOR,
    SEL_ACK,
    SEL_RXS,
    SEL_NONE
  } ctl_sel_e;

  // outgoing slice length per channel, in 32-bit words
  function automatic int out_words(input int ch);
    case (ch)
      0: return 4;  1: return 8;  2: return 3;  3: return 6;
      4: return 9;  5: return 4;  6: return 6;  7: return 6;
      8: return 1;  9: return 4;  10: return 4; default: return 1;
    endcase
  endfunction

  // reply slice length per channel, in 32-bit words
  function automatic int in_words(input int ch);
    case (ch)
      0: return 4;  1: return 8;  2: return 1;  3: return 1;
      4: return 1;  5: return 4;  6: return 1;  7: return 6;
      8: return 4;  9: return 1;  10: return 4; default: return 1;
    endcase
  endfunction

  function automatic int sum_out(input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += out_words(i);
    return s;
  endfunction

  function automatic int sum_in(input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += in_words(i);
    return s;
  endfunction

  localparam int OUT_WORDS   = sum_out(NUM_CH);
  localparam int IN_WORDS    = sum_in(NUM_CH);
  localparam int TOTAL_WORDS = OUT_WORDS + IN_WORDS;

endpackage

// File: rtl/mbx_chan_flag.sv
module mbx_chan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic door,
  input  logic consume,
  input  logic respond,
  input  logic ack,
  output logic tx_busy,
  output logic rx_full
);

  logic tx_nxt;
  logic rx_nxt;

  always_comb begin
    tx_nxt = tx_busy;
    if (consume) tx_nxt = 1'b0;
    if (door)    tx_nxt = 1'b1;
    rx_nxt = rx_full;
    if (ack)     rx_nxt = 1'b0;
    if (respond) rx_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      tx_busy <= tx_nxt;
      rx_full <= rx_nxt;
    end
  end

  a_r3_door_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    door |=> tx_busy);
  a_r4_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !door) |=> !tx_busy);
  a_r5_respond_wins: assert property (@(posedge clk) disable iff (!rst_n)
    respond |=> rx_full);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !respond) |=> !rx_full);

endmodule

// File: rtl/mbx_data_ram.sv
module mbx_data_ram #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 7,
  parameter int WORDS    = 92,
  parameter int HOST_END = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              rmt_we,
  input  logic [IDX_W-1:0]  rmt_idx,
  input  logic [DATA_W-1:0] rmt_wdata,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] mem     [WORDS];
  logic [DATA_W-1:0] mem_nxt [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic host_hit;
    logic rmt_hit;

    if (w < HOST_END) begin : g_host_area
      assign host_hit = host_we && (host_idx == IDX_W'(w));
      assign rmt_hit  = 1'b0;
    end else begin : g_rmt_area
      assign host_hit = 1'b0;
      assign rmt_hit  = rmt_we && (rmt_idx == IDX_W'(w));
    end

    always_comb begin
      mem_nxt[w] = mem[w];
      if (host_hit) mem_nxt[w] = host_wdata;
      if (rmt_hit)  mem_nxt[w] = rmt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[w] <= '0;
      else if (host_hit || rmt_hit) mem[w] <= mem_nxt[w];
    end

    if (w >= HOST_END) begin : g_chk_host
      a_r7_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_idx == IDX_W'(w) && !(rmt_we && rmt_idx == IDX_W'(w)))
        |=> $stable(mem[w]));
    end else begin : g_chk_rmt
      a_r7_rmt_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_we && rmt_idx == IDX_W'(w) && !(host_we && host_idx == IDX_W'(w)))
        |=> $stable(mem[w]));
    end
  end

  assign rd_a_data = (rd_a_idx < IDX_W'(WORDS)) ? mem[rd_a_idx] : '0;
  assign rd_b_data = (rd_b_idx < IDX_W'(WORDS)) ? mem[rd_b_idx] : '0;

endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mbx_clk_en,
  input  logic                hst_req,
  input  logic                hst_we,
  input  logic                hst_ctl,
  input  logic [ADDR_W-1:0]   hst_addr,
  input  logic [DATA_W-1:0]   hst_wdata,
  output logic [DATA_W-1:0]   hst_rdata,
  input  logic [NUM_CH-1:0]   rmt_consume,
  input  logic [NUM_CH-1:0]   rmt_respond,
  input  logic                rmt_we,
  input  logic [ADDR_W-3:0]   rmt_idx,
  input  logic [DATA_W-1:0]   rmt_wdata,
  output logic [DATA_W-1:0]   rmt_rdata,
  output logic [NUM_CH-1:0]   tx_busy,
  output logic                irq
);

  localparam int IDX_W = ADDR_W - 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  // host access qualification
  logic     host_go;
  logic     ctl_wr;
  logic     dat_wr;
  logic     rd_go;
  ctl_sel_e ctl_sel;

  assign host_go = hst_req && mbx_clk_en;
  assign ctl_wr  = host_go && hst_we && hst_ctl;
  assign dat_wr  = host_go && hst_we && !hst_ctl;
  assign rd_go   = host_go && !hst_we;

  always_comb begin
    case (hst_addr)
      ADDR_W'(OFF_TX_STAT):  ctl_sel = SEL_TXS;
      ADDR_W'(OFF_DOORBELL): ctl_sel = SEL_DOOR;
      ADDR_W'(OFF_ACK):      ctl_sel = SEL_ACK;
      ADDR_W'(OFF_RX_STAT):  ctl_sel = SEL_RXS;
      default:               ctl_sel = SEL_NONE;
    endcase
  end

  logic [NUM_CH-1:0] door_vec;
  logic [NUM_CH-1:0] ack_vec;
  logic [NUM_CH-1:0] rx_full;

  assign door_vec = (ctl_wr && ctl_sel == SEL_DOOR) ? hst_wdata[NUM_CH-1:0] : '0;
  assign ack_vec  = (ctl_wr && ctl_sel == SEL_ACK)  ? hst_wdata[NUM_CH-1:0] : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    mbx_chan_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .door    (door_vec[c]),
      .consume (rmt_consume[c]),
      .respond (rmt_respond[c]),
      .ack     (ack_vec[c]),
      .tx_busy (tx_busy[c]),
      .rx_full (rx_full[c])
    );
  end

  // data window
  logic [DATA_W-1:0] ram_rd;

  mbx_data_ram #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .WORDS    (TOTAL_WORDS),
    .HOST_END (OUT_WORDS)
  ) u_ram (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .host_we    (dat_wr),
    .host_idx   (hst_addr[ADDR_W-1:2]),
    .host_wdata (hst_wdata),
    .rmt_we     (rmt_we),
    .rmt_idx    (rmt_idx),
    .rmt_wdata  (rmt_wdata),
    .rd_a_idx   (hst_addr[ADDR_W-1:2]),
    .rd_a_data  (ram_rd),
    .rd_b_idx   (rmt_idx),
    .rd_b_data  (rmt_rdata)
  );

  // read path and interrupt
  logic [DATA_W-1:0] rd_nxt;
  logic              irq_nxt;

  always_comb begin
    rd_nxt = '0;
    if (hst_ctl) begin
      case (ctl_sel)
        SEL_TXS: rd_nxt = DATA_W'(tx_busy);
        SEL_RXS: rd_nxt = DATA_W'(rx_full);
        default: rd_nxt = '0;
      endcase
    end else begin
      rd_nxt = ram_rd;
    end
    irq_nxt = |rx_full;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hst_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd_go) hst_rdata <= rd_nxt;
      irq <= irq_nxt;
    end
  end

  a_r6_irq_raise: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|rx_full) |=> irq);
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_full == '0) |=> !irq);
  a_r9_no_gated_door: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mbx_clk_en |=> ((tx_busy & ~$past(tx_busy)) == '0));
  a_r9_no_gated_ack: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mbx_clk_en |=> (($past(rx_full) & ~rx_full) == '0));
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mbx_clk_en |=> $stable(hst_rdata));

endmodule

// File: tb/doorbell_mailbox_bench.sv
module doorbell_mailbox_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mbx_clk_en;
  logic        hst_req, hst_we, hst_ctl;
  logic [8:0]  hst_addr;
  logic [31:0] hst_wdata;
  logic [31:0] hst_rdata;
  logic [11:0] rmt_consume, rmt_respond;
  logic        rmt_we;
  logic [6:0]  rmt_idx;
  logic [31:0] rmt_wdata;
  logic [31:0] rmt_rdata;
  logic [11:0] tx_busy;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  doorbell_mailbox u_doorbell_mailbox (
    .clk(clk), .rst_n(rst_n), .mbx_clk_en(mbx_clk_en),
    .hst_req(hst_req), .hst_we(hst_we), .hst_ctl(hst_ctl),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .rmt_consume(rmt_consume), .rmt_respond(rmt_respond),
    .rmt_we(rmt_we), .rmt_idx(rmt_idx), .rmt_wdata(rmt_wdata),
    .rmt_rdata(rmt_rdata), .tx_busy(tx_busy), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic ctl, input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b1; hst_ctl = ctl; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0;
  endtask

  task automatic hr(input logic ctl, input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b0; hst_ctl = ctl; hst_addr = a;
    @(negedge clk);
    hst_req = 1'b0;
    d = hst_rdata;
  endtask

  task automatic rwr(input logic [6:0] idx, input logic [31:0] d);
    @(negedge clk);
    rmt_we = 1'b1; rmt_idx = idx; rmt_wdata = d;
    @(negedge clk);
    rmt_we = 1'b0;
  endtask

  task automatic consume(input logic [11:0] m);
    @(negedge clk); rmt_consume = m;
    @(negedge clk); rmt_consume = '0;
  endtask

  task automatic respond(input logic [11:0] m);
    @(negedge clk); rmt_respond = m;
    @(negedge clk); rmt_respond = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 tx_busy", 32'(tx_busy), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    hr(1'b1, 9'h000, d); check("R1 tx status", d, 32'h0);
    hr(1'b1, 9'h078, d); check("R1 rx status", d, 32'h0);
  endtask

  task automatic t_data;
    logic [31:0] d;
    hw(1'b0, 9'h000, 32'hA5A5_0001);
    hw(1'b0, 9'h0dc, 32'hC0DE_0055);
    hw(1'b0, 9'h004, 32'h1111_1111);
    hr(1'b0, 9'h000, d); check("R2 word 0", d, 32'hA5A5_0001);
    hr(1'b0, 9'h0dc, d); check("R2 word 55", d, 32'hC0DE_0055);
    // R11: the request is sampled at one edge and the data shows after it
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b0; hst_ctl = 1'b0; hst_addr = 9'h004;
    check("R11 before edge", hst_rdata, 32'hC0DE_0055);
    @(negedge clk);
    hst_req = 1'b0;
    check("R11 after edge", hst_rdata, 32'h1111_1111);
  endtask

  task automatic t_doorbell;
    logic [31:0] d;
    hw(1'b1, 9'h004, 32'h0000_0801);
    check("R3 tx_busy", 32'(tx_busy), 32'h801);
    hr(1'b1, 9'h000, d); check("R3 tx status", d, 32'h801);
    hw(1'b1, 9'h004, 32'h0);
    check("R3 zero bits", 32'(tx_busy), 32'h801);
    check("R6 no irq on tx", 32'(irq), 32'h0);
  endtask

  task automatic t_consume;
    consume(12'h001);
    check("R4 consume ch0", 32'(tx_busy), 32'h800);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b1; hst_ctl = 1'b1; hst_addr = 9'h004;
    hst_wdata = 32'h800; rmt_consume = 12'h800;
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0; rmt_consume = '0;
    check("R4 door wins", 32'(tx_busy), 32'h800);
    consume(12'h800);
    check("R4 consume ch11", 32'(tx_busy), 32'h0);
    @(negedge clk);
    check("R6 idle irq", 32'(irq), 32'h0);
  endtask

  task automatic t_reply;
    logic [31:0] d;
    rwr(7'd56, 32'hBEEF_0056);
    rwr(7'd91, 32'hBEEF_0091);
    hr(1'b0, 9'h0e0, d); check("R8 word 56", d, 32'hBEEF_0056);
    hr(1'b0, 9'h16c, d); check("R8 word 91", d, 32'hBEEF_0091);
    @(negedge clk); rmt_idx = 7'd91; #1;
    check("R8 rmt_rdata", rmt_rdata, 32'hBEEF_0091);
    respond(12'h080);
    check("R6 irq latency", 32'(irq), 32'h0);
    @(negedge clk);
    check("R6 irq up", 32'(irq), 32'h1);
    hr(1'b1, 9'h078, d); check("R5 rx status", d, 32'h080);
    hw(1'b1, 9'h074, 32'h0);
    hr(1'b1, 9'h078, d); check("R5 ack zero bits", d, 32'h080);
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b1; hst_ctl = 1'b1; hst_addr = 9'h074;
    hst_wdata = 32'h080; rmt_respond = 12'h080;
    @(negedge clk);
    hst_req = 1'b0; hst_we = 1'b0; rmt_respond = '0;
    hr(1'b1, 9'h078, d); check("R5 respond wins", d, 32'h080);
    hw(1'b1, 9'h074, 32'h080);
    check("R6 irq held one cycle", 32'(irq), 32'h1);
    @(negedge clk);
    check("R6 irq down", 32'(irq), 32'h0);
    hr(1'b1, 9'h078, d); check("R5 ack clears", d, 32'h0);
  endtask

  task automatic t_areas;
    logic [31:0] d;
    hw(1'b0, 9'h0e0, 32'hDEAD_DEAD);
    hr(1'b0, 9'h0e0, d); check("R7 host blocked", d, 32'hBEEF_0056);
    rwr(7'd0, 32'hDEAD_0000);
    hr(1'b0, 9'h000, d); check("R7 remote blocked", d, 32'hA5A5_0001);
    rwr(7'd55, 32'hDEAD_0055);
    hr(1'b0, 9'h0dc, d); check("R7 remote blocked 55", d, 32'hC0DE_0055);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    hr(1'b0, 9'h000, d);
    mbx_clk_en = 1'b0;
    hw(1'b1, 9'h004, 32'h008);
    check("R9 gated doorbell", 32'(tx_busy), 32'h0);
    hw(1'b0, 9'h004, 32'h2222_2222);
    hr(1'b0, 9'h004, d); check("R9 rdata holds", d, 32'hA5A5_0001);
    respond(12'h004);
    hw(1'b1, 9'h074, 32'h004);
    @(negedge clk);
    check("R9 gated ack", 32'(irq), 32'h1);
    mbx_clk_en = 1'b1;
    hr(1'b0, 9'h004, d); check("R9 gated data write", d, 32'h1111_1111);
    hr(1'b1, 9'h078, d); check("R9 rx survives", d, 32'h004);
    hw(1'b1, 9'h074, 32'h004);
    hr(1'b1, 9'h078, d); check("R5 ack ch2", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    hw(1'b1, 9'h004, 32'h001);
    hr(1'b1, 9'h004, d); check("R10 doorbell reads 0", d, 32'h0);
    hr(1'b1, 9'h074, d); check("R10 ack reads 0", d, 32'h0);
    hr(1'b1, 9'h010, d); check("R10 unmapped ctl", d, 32'h0);
    hr(1'b0, 9'h170, d); check("R10 past window", d, 32'h0);
    hr(1'b0, 9'h1fc, d); check("R10 top address", d, 32'h0);
    consume(12'h001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mbx_clk_en = 1'b1;
    hst_req = 1'b0; hst_we = 1'b0; hst_ctl = 1'b0; hst_addr = '0; hst_wdata = '0;
    rmt_consume = '0; rmt_respond = '0; rmt_we = 1'b0; rmt_idx = '0; rmt_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_data();
    t_doorbell();
    t_consume();
    t_reply();
    t_areas();
    t_gate();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule